// File: doc/BRIEF.md
# Way-Lockable Cache Tag Controller

This block keeps the tag store, valid bits and replacement order for a 16-Kbyte, four-way set-associative cache indexed by physical address. It receives a 32-bit physical address, decides whether the line is present and in which way, and reports the result. On a miss it picks a victim way, writes the new tag into that way and marks it valid. The data array, line fills from memory, coherency and dirty-line write-back are handled elsewhere. This block only says which way holds or will hold the line.

Software can pin the lowest one, two or three ways, or the whole cache. Pinned ways still return hits and still refresh their recency, but they are never chosen for replacement. When the whole cache is pinned, a miss allocates nothing.

Lookups arrive on a valid/ready request port, and results leave on a valid/ready response port. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the following cycle and stays stable until `rsp_ready` is seen high. While a response is waiting, `req_ready` stays low, so at most one result is ever in flight. A pulse on `inv_start` clears every valid bit, one set per cycle. `req_ready` stays low while that sweep runs. The lock controls are plain static inputs and are sampled at the same edge as the request.

Top module: `wlc_top`

## Requirements
- R1: The 32-bit address splits into a 20-bit tag (bits 31:12), a 7-bit set index (bits 11:5) and a 5-bit byte offset (bits 4:0). The offset has no effect on the lookup.
- R2: The response appears in the cycle after acceptance. For a hit, `rsp_hit`=1, `rsp_alloc`=0 and `rsp_way` gives the way holding the tag.
- R3: On a miss where some candidate way of the set is invalid, the lowest-numbered invalid candidate is allocated. The response shows `rsp_hit`=0, `rsp_alloc`=1 and `rsp_way` set to that way, and a later lookup of the same address hits there.
- R4: On a miss where every candidate way is valid, the least recently used candidate is evicted and replaced by the new tag.
- R5: Every hit makes its way the most recent in its set, including a hit in a locked way. Every allocation does the same for the allocated way.
- R6: With `lock_ways`=N (N from 1 to 3) and `lock_all`=0, ways 0 to N-1 are never allocated. Their lines still return hits. `lock_ways`=0 locks nothing.
- R7: With `lock_all`=1, a miss returns `rsp_alloc`=0 and `rsp_way`=0 and leaves tags, valid bits and recency unchanged. Hits are still reported.
- R8: After a single-cycle `inv_start`, `inv_busy` is high for exactly 128 cycles starting at the next edge. `req_ready` is low for that whole time, and every lookup afterwards misses.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response fields stay unchanged and `req_ready` is low.
- R10: After reset there are no valid lines, `rsp_valid`=0, `inv_busy`=0 and `req_ready`=1. Each set's recency order starts with way 0 most recent and way 3 least recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Physical address to look up |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Line was present |
| rsp_alloc | output | 1 | Miss caused a new tag to be written |
| rsp_way | output | 2 | Hit way, or allocated way on a fill |
| lock_ways | input | 2 | Number of low ways pinned (0 to 3) |
| lock_all | input | 1 | Pin the entire cache |
| inv_start | input | 1 | Start a full invalidate sweep |
| inv_busy | output | 1 | Invalidate sweep in progress |

## Verification
The bench aims at the following corner cases:
- **Victim in a partly locked set.** A design that ignored the lock count would place new lines in pinned ways. A design that counted a locked hit as no use would evict in the wrong order.
- **Whole-cache lock.** A design that still wrote tags while the whole cache was pinned would turn a repeated miss into a hit.
- **Offset bits and fill order.** A wrong index slice or offset handling would turn a same-line access into a miss. A wrong fill order would choose a valid line while an invalid way was free.
- **Random mixes.** Random mixes with a stalling consumer stress response holding and back-to-back same-set updates.
- **Invalidate sweep.** The sweep length is counted cycle by cycle, and every line must miss afterwards.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  typedef enum logic {
    INV_IDLE = 1'b0,
    INV_RUN  = 1'b1
  } inv_state_t;

  typedef struct packed {
    logic hit;
    logic alloc;
  } rsp_kind_t;
endpackage

// File: rtl/wlc_tag_store.sv
module wlc_tag_store #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int IDX_W = 7,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  vld_vec,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (sel) tag_q[lk_idx] <= wr_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= '0;
      else if (clr_en) vld_q[clr_idx] <= 1'b0;
      else if (sel)    vld_q[lk_idx] <= 1'b1;
    end

    assign vld_vec[w] = vld_q[lk_idx];
    assign hit_vec[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end
endmodule

// File: rtl/wlc_lru.sv
module wlc_lru #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int IDX_W = 7,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  output logic [WAYS-1:0][WAY_W-1:0]  ages,
  input  logic                        upd_en,
  input  logic [WAY_W-1:0]            upd_way
);
  // age 0 = most recent, WAYS-1 = least recent
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] row_nxt;

  assign ages = age_q[idx];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == upd_way)          row_nxt[w] = '0;
      else if (ages[w] < ages[upd_way])  row_nxt[w] = ages[w] + 1'b1;
      else                               row_nxt[w] = ages[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (upd_en) begin
      age_q[idx] <= row_nxt;
    end
  end
endmodule

// File: rtl/wlc_victim.sv
module wlc_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]             vld_vec,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages,
  input  logic [WAY_W-1:0]            lock_n,
  input  logic                        lock_all,
  output logic [WAY_W-1:0]            vic_way,
  output logic                        vic_ok
);
  logic             have_inv;
  logic [WAY_W-1:0] inv_way;
  logic             have_old;
  logic [WAY_W-1:0] old_way;
  logic [WAY_W-1:0] old_age;

  always_comb begin
    have_inv = 1'b0;
    inv_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (w >= int'(lock_n) && !vld_vec[w]) begin
        have_inv = 1'b1;
        inv_way  = WAY_W'(w);
      end
    end
  end

  always_comb begin
    have_old = 1'b0;
    old_way  = '0;
    old_age  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (w >= int'(lock_n) && (!have_old || ages[w] > old_age)) begin
        have_old = 1'b1;
        old_way  = WAY_W'(w);
        old_age  = ages[w];
      end
    end
  end

  assign vic_ok  = !lock_all && (have_inv || have_old);
  assign vic_way = have_inv ? inv_way : old_way;
endmodule

// File: rtl/wlc_top.sv
module wlc_top #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_hit,
  output logic                     rsp_alloc,
  output logic [$clog2(WAYS)-1:0]  rsp_way,
  input  logic [$clog2(WAYS)-1:0]  lock_ways,
  input  logic                     lock_all,
  input  logic                     inv_start,
  output logic                     inv_busy
);
  import wlc_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             unused_off;

  assign lk_idx     = req_addr[OFF_W +: IDX_W];
  assign lk_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  inv_state_t       inv_st;
  logic [IDX_W-1:0] inv_cnt;
  logic             accept;

  assign inv_busy  = (inv_st == INV_RUN);
  assign req_ready = !inv_busy && !inv_start && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  logic [WAYS-1:0]            hit_vec;
  logic [WAYS-1:0]            vld_vec;
  logic [WAYS-1:0][WAY_W-1:0] ages;
  logic [WAY_W-1:0]           vic_way;
  logic                       vic_ok;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic                       fill;
  rsp_kind_t                  kind;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign hit  = |hit_vec;
  assign fill = accept && !hit && vic_ok;
  assign kind = '{hit: hit, alloc: !hit && vic_ok};

  wlc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_idx  (lk_idx),
    .lk_tag  (lk_tag),
    .hit_vec (hit_vec),
    .vld_vec (vld_vec),
    .wr_en   (fill),
    .wr_way  (vic_way),
    .wr_tag  (lk_tag),
    .clr_en  (inv_busy),
    .clr_idx (inv_cnt)
  );

  wlc_lru #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (lk_idx),
    .ages    (ages),
    .upd_en  (accept && (hit || vic_ok)),
    .upd_way (hit ? hit_way : vic_way)
  );

  wlc_victim #(
    .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_vic (
    .vld_vec  (vld_vec),
    .ages     (ages),
    .lock_n   (lock_ways),
    .lock_all (lock_all),
    .vic_way  (vic_way),
    .vic_ok   (vic_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_alloc <= 1'b0;
      rsp_way   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= kind.hit;
      rsp_alloc <= kind.alloc;
      rsp_way   <= hit ? hit_way : (vic_ok ? vic_way : '0);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_st  <= INV_IDLE;
      inv_cnt <= '0;
    end else begin
      unique case (inv_st)
        INV_IDLE: if (inv_start) begin
          inv_st  <= INV_RUN;
          inv_cnt <= '0;
        end
        INV_RUN: begin
          if (inv_cnt == IDX_W'(SETS - 1)) inv_st <= INV_IDLE;
          inv_cnt <= inv_cnt + 1'b1;
        end
        default: inv_st <= INV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
  parameter int SETS  = 128,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_alloc,
  input logic [WAY_W-1:0] rsp_way,
  input logic [WAY_W-1:0] lock_ways,
  input logic             lock_all,
  input logic             inv_busy
);
  logic        acc;
  int unsigned busy_run;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run <= 0;
    else if (inv_busy) busy_run <= busy_run + 1;
    else               busy_run <= 0;
  end

  // R2
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
                                   && $stable(rsp_alloc) && $stable(rsp_way)));

  // R9
  bp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R8
  inv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !req_ready);

  // R8
  inv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> (busy_run < SETS));

  // R3
  alloc_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_alloc) |-> !rsp_hit);

  // R6
  lock_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !lock_all) |=> (!rsp_alloc || rsp_way >= $past(lock_ways)));

  // R7
  lock_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lock_all) |=> !rsp_alloc);
endmodule

bind wlc_top wlc_checker #(.SETS(SETS), .WAY_W($clog2(WAYS))) u_wlc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_alloc (rsp_alloc),
  .rsp_way   (rsp_way),
  .lock_ways (lock_ways),
  .lock_all  (lock_all),
  .inv_busy  (inv_busy)
);

// File: tb/wlc_top_bench.sv
module wlc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic        rsp_alloc;
  logic [1:0]  rsp_way;
  logic [1:0]  lock_ways = '0;
  logic        lock_all = 1'b0;
  logic        inv_start = 1'b0;
  logic        inv_busy;

  always #5 clk = ~clk;

  wlc_top u_wlc_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_alloc(rsp_alloc), .rsp_way(rsp_way),
    .lock_ways(lock_ways), .lock_all(lock_all), .inv_start(inv_start),
    .inv_busy(inv_busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int bp_viol = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  // reference model
  logic [19:0] m_tag [4][128];
  bit          m_vld [4][128];
  int          m_age [4][128];

  logic [3:0] exp_q [$];
  string      lbl_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return {20'(tag), 7'(idx), 5'(off)};
  endfunction

  task automatic touch(input int idx, input int w);
    int aw = m_age[w][idx];
    for (int j = 0; j < 4; j++) begin
      if (j == w) m_age[j][idx] = 0;
      else if (m_age[j][idx] < aw) m_age[j][idx]++;
    end
  endtask

  task automatic model(input logic [31:0] a, input int ln, input bit la,
                       output logic [3:0] res);
    int idx = int'(a[11:5]);
    logic [19:0] tg = a[31:12];
    int vic = -1;
    for (int w = 0; w < 4; w++)
      if (m_vld[w][idx] && m_tag[w][idx] == tg) begin
        touch(idx, w);
        res = {1'b1, 1'b0, 2'(w)};
        return;
      end
    if (la) begin
      res = 4'b0000;
      return;
    end
    for (int w = 3; w >= ln; w--)
      if (!m_vld[w][idx]) vic = w;
    if (vic < 0) begin
      int best = -1;
      for (int w = ln; w < 4; w++)
        if (m_age[w][idx] > best) begin
          best = m_age[w][idx];
          vic = w;
        end
    end
    m_tag[vic][idx] = tg;
    m_vld[vic][idx] = 1'b1;
    touch(idx, vic);
    res = {1'b0, 1'b1, 2'(vic)};
  endtask

  task automatic do_req(input logic [31:0] a, input int ln, input bit la,
                        input string lbl);
    logic [3:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    lock_ways = 2'(ln);
    lock_all  = la;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    model(a, ln, la, e);
    exp_q.push_back(e);
    lbl_q.push_back(lbl);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  // consumer ready pattern
  always @(posedge clk) begin
    #2 rsp_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid && !rsp_ready && req_ready) bp_viol++;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected response", 1, 0);
        end else begin
          logic [3:0] e;
          string l;
          e = exp_q.pop_front();
          l = lbl_q.pop_front();
          check({rsp_hit, rsp_alloc, rsp_way} == e, l, "{hit,alloc,way}",
                int'({rsp_hit, rsp_alloc, rsp_way}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin
        m_vld[w][s] = 1'b0;
        m_age[w][s] = w;
        m_tag[w][s] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rsp_valid == 1'b0, "R10", "rsp_valid", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R10", "req_ready", int'(req_ready), 1);
    check(inv_busy == 1'b0, "R10", "inv_busy", int'(inv_busy), 0);

    // R3 fills go to lowest invalid way; R1 offset ignored, R2 hit way
    for (int t = 0; t < 4; t++) do_req(mk(16 + t, 5, 0), 0, 0, "R3");
    do_req(mk(16, 5, 31), 0, 0, "R1");
    do_req(mk(18, 5, 7), 0, 0, "R2");
    do_req(mk(16, 6, 0), 0, 0, "R1");
    // R4 eviction of least recent, R5 hits refresh recency
    do_req(mk(17, 5, 0), 0, 0, "R5");
    do_req(mk(40, 5, 0), 0, 0, "R4");
    do_req(mk(41, 5, 0), 0, 0, "R4");
    do_req(mk(40, 5, 3), 0, 0, "R4");
    drain();

    // R6 partial locks; locked lines still hit and refresh (R5)
    for (int n = 1; n < 4; n++) begin
      for (int t = 0; t < 5; t++) do_req(mk(100 + 10 * n + t, 9, 0), n, 0, "R6");
      do_req(mk(100 + 10 * n, 9, 0), n, 0, "R6");
    end
    do_req(mk(110, 9, 0), 3, 0, "R5");
    for (int t = 0; t < 3; t++) do_req(mk(200 + t, 10, 0), 2, 0, "R6");
    drain();

    // R7 whole-cache lock
    do_req(mk(500, 5, 0), 0, 1, "R7");
    do_req(mk(500, 5, 0), 0, 1, "R7");
    do_req(mk(17, 5, 0), 0, 1, "R7");
    do_req(mk(501, 12, 0), 0, 1, "R7");
    do_req(mk(501, 12, 0), 0, 0, "R7");
    drain();

    // R9 back-pressure with random mix
    bp_en = 1'b1;
    for (int i = 0; i < 400; i++)
      do_req(mk($urandom % 6, $urandom % 4, $urandom % 32),
             $urandom % 4, ($urandom % 8) == 0, "R9");
    drain();
    bp_en = 1'b0;
    @(negedge clk);
    check(bp_viol == 0, "R9", "ready while stalled", bp_viol, 0);

    // R8 invalidate sweep
    begin
      int busy = 0;
      int rdy_hi = 0;
      @(negedge clk);
      inv_start = 1'b1;
      @(negedge clk);
      inv_start = 1'b0;
      while (inv_busy && busy < 1000) begin
        busy++;
        if (req_ready) rdy_hi++;
        @(negedge clk);
      end
      check(busy == 128, "R8", "busy cycles", busy, 128);
      check(rdy_hi == 0, "R8", "ready during sweep", rdy_hi, 0);
      for (int s = 0; s < 128; s++)
        for (int w = 0; w < 4; w++) m_vld[w][s] = 1'b0;
    end
    do_req(mk(16, 5, 0), 0, 0, "R8");
    do_req(mk(110, 9, 0), 0, 0, "R8");
    do_req(mk(16, 5, 0), 0, 0, "R8");
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule